// File: doc/BRIEF.md
# Counter Command Byte with Touch-Probe Capture

This block decodes one write-only command byte for a multi-channel incremental counter. A register write that hits the command address turns each set command bit into an action. Counter-clear, zero-codification-enable and touch-probe-capture bits are one-shot: each fires for a single clock and is then gone, so software never has to write it back to zero. Two actuator bits work differently. They are stored and drive two level outputs until the next write to the same address changes them.

The block also holds the two-stage touch-probe chain. On a capture command, the older stage takes the newer stage's value and the newer stage takes the live count, both in one step. A capture only happens while the counter reports 24-bit operation. Otherwise the request is dropped.

Top module: `cntcmd_top`

## Requirements
- R1: While reset is asserted and after it is released with no write, all pulse outputs are low, both actuator outputs are low, and both capture stages read zero.
- R2: A write to address 0x30 with data bit 0, 1 or 2 set drives cntRstPulse[0], [1] or [2] high for exactly the one clock cycle after the write cycle.
- R3: A write to address 0x30 with data bit 3 set drives zeroEnPulse high for exactly the one clock cycle after the write cycle.
- R4: A write to address 0x30 with data bit 4 set while mode24 is high drives capturePulse high for the cycle after the write. From that cycle on, tp2 holds the previous tp1 and tp1 holds the countIn value present in the write cycle.
- R5: When mode24 is low during a write with data bit 4 set, no capture pulse occurs and tp1 and tp2 keep their values.
- R6: Every write to address 0x30 loads data bits 5 and 6 into actOut[0] and actOut[1] (1 = high). The outputs change in the cycle after the write and hold between writes.
- R7: A write to any address other than 0x30 produces no pulse and changes neither the actuator outputs nor the capture stages.
- R8: Data bit 7 of a command write has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| countIn | input | 24 | Live counter value for capture |
| mode24 | input | 1 | Counter is in 24-bit mode |
| cntRstPulse | output | 3 | One-cycle clear pulse per counter |
| zeroEnPulse | output | 1 | One-cycle zero-codification enable |
| capturePulse | output | 1 | One-cycle capture indication |
| actOut | output | 2 | Actuator levels |
| tp1 | output | 24 | Newer capture stage |
| tp2 | output | 24 | Older capture stage |

## Verification
The bench issues writes on consecutive cycles. A design that stretched a pulse, or that cleared a bit only after a gap, would show a pulse that is too long or one that is missing. Back-to-back captures with a count that changes every cycle expose a chain that shifts in the wrong order or samples the count one cycle late. Captures with mode24 low, writes to a neighbouring address, and writes with only bit 7 set catch a decoder that ignores the mode or matches too few address bits. A pulse write that leaves the actuator bits clear must drop both actuators, which shows up an actuator that is wrongly made sticky against writes.

// File: rtl/cntcmd_pkg.sv
package cntcmd_pkg;
  localparam int NUM_CNT     = 3;
  localparam int NUM_ACT     = 2;
  localparam int BIT_ZERO    = 3;
  localparam int BIT_CAPTURE = 4;
  localparam int BIT_ACT0    = 5;

  typedef struct packed {
    logic [NUM_CNT-1:0] cntRst;
    logic               zeroEn;
    logic               capture;
  } cmd_strobe_t;
endpackage

// File: rtl/cntcmd_ctrl.sv
module cntcmd_ctrl
  import cntcmd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 mode24,
  output cmd_strobe_t          strobe,
  output logic [NUM_CNT-1:0]   cntRstPulse,
  output logic                 zeroEnPulse,
  output logic                 capturePulse,
  output logic [NUM_ACT-1:0]   actOut
);
  localparam int TOP_USED = BIT_ACT0 + NUM_ACT;

  logic hit;
  logic unusedHighBits;

  assign hit = wrEn && (wrAddr == CMD_ADDR);
  assign unusedHighBits = ^wrData[DATA_W-1:TOP_USED];

  always_comb begin
    strobe         = '0;
    strobe.cntRst  = hit ? wrData[NUM_CNT-1:0] : '0;
    strobe.zeroEn  = hit && wrData[BIT_ZERO];
    strobe.capture = hit && wrData[BIT_CAPTURE] && mode24;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_rst
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntRstPulse[i] <= 1'b0;
      else       cntRstPulse[i] <= strobe.cntRst[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroEnPulse  <= 1'b0;
      capturePulse <= 1'b0;
    end else begin
      zeroEnPulse  <= strobe.zeroEn;
      capturePulse <= strobe.capture;
    end
  end

  for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    actOut[a] <= 1'b0;
      else if (hit) actOut[a] <= wrData[BIT_ACT0 + a];
    end
  end
endmodule

// File: rtl/cntcmd_data.sv
module cntcmd_data
  import cntcmd_pkg::*;
#(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmd_strobe_t        strobe,
  input  logic [COUNT_W-1:0] countIn,
  output logic [COUNT_W-1:0] tp1,
  output logic [COUNT_W-1:0] tp2
);
  logic unusedStrobe;
  assign unusedStrobe = strobe.zeroEn ^ (^strobe.cntRst);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tp1 <= '0;
      tp2 <= '0;
    end else if (strobe.capture) begin
      tp2 <= tp1;
      tp1 <= countIn;
    end
  end
endmodule

// File: rtl/cntcmd_top.sv
module cntcmd_top
  import cntcmd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 24,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [COUNT_W-1:0] countIn,
  input  logic               mode24,
  output logic [NUM_CNT-1:0] cntRstPulse,
  output logic               zeroEnPulse,
  output logic               capturePulse,
  output logic [NUM_ACT-1:0] actOut,
  output logic [COUNT_W-1:0] tp1,
  output logic [COUNT_W-1:0] tp2
);
  cmd_strobe_t strobe;

  cntcmd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mode24(mode24), .strobe(strobe), .cntRstPulse(cntRstPulse),
    .zeroEnPulse(zeroEnPulse), .capturePulse(capturePulse), .actOut(actOut)
  );

  cntcmd_data #(.COUNT_W(COUNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countIn(countIn),
    .tp1(tp1), .tp2(tp2)
  );
endmodule

// File: rtl/cntcmd_checker.sv
module cntcmd_checker
  import cntcmd_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 24,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h30
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic [COUNT_W-1:0] countIn,
  input logic               mode24,
  input logic [NUM_CNT-1:0] cntRstPulse,
  input logic               zeroEnPulse,
  input logic               capturePulse,
  input logic [NUM_ACT-1:0] actOut,
  input logic [COUNT_W-1:0] tp1,
  input logic [COUNT_W-1:0] tp2
);
  logic hitNow;
  assign hitNow = wrEn && (wrAddr == CMD_ADDR);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    p_rst_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
      cntRstPulse[i] |-> $past(hitNow && wrData[i]));
  end

  p_zero_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    zeroEnPulse |-> $past(hitNow && wrData[BIT_ZERO]));

  p_tp_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    capturePulse |-> (tp2 == $past(tp1)) && (tp1 == $past(countIn)));

  p_capture_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    capturePulse |-> $past(mode24));

  p_tp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !capturePulse |-> $stable(tp1) && $stable(tp2));

  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hitNow) |-> $stable(actOut));
endmodule

bind cntcmd_top cntcmd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W), .CMD_ADDR(CMD_ADDR)
) u_checker (.*);

// File: tb/cntcmd_top_bench.sv
module cntcmd_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [23:0] countIn = '0;
  logic        mode24 = 1'b1;
  logic [2:0]  cntRstPulse;
  logic        zeroEnPulse;
  logic        capturePulse;
  logic [1:0]  actOut;
  logic [23:0] tp1;
  logic [23:0] tp2;

  int checks = 0;
  int errors = 0;
  string scen = "R1";
  bit started = 1'b0;

  logic [2:0]  expRst = '0;
  logic        expZero = 1'b0;
  logic        expCap = 1'b0;
  logic [1:0]  expAct = '0;
  logic [23:0] expTp1 = '0;
  logic [23:0] expTp2 = '0;

  always #2 clk = ~clk;

  cntcmd_top u_cntcmd_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countIn(countIn), .mode24(mode24), .cntRstPulse(cntRstPulse),
    .zeroEnPulse(zeroEnPulse), .capturePulse(capturePulse), .actOut(actOut),
    .tp1(tp1), .tp2(tp2)
  );

  // Behavioural reference, updated on each rising edge from sampled inputs.
  always @(posedge clk) begin
    bit hit;
    if (!rstN) begin
      expRst <= '0; expZero <= 0; expCap <= 0; expAct <= '0;
      expTp1 <= '0; expTp2 <= '0;
    end else begin
      hit = wrEn && (wrAddr == 8'h30);
      expRst  <= hit ? wrData[2:0] : 3'b000;
      expZero <= hit && wrData[3];
      expCap  <= hit && wrData[4] && mode24;
      if (hit && wrData[4] && mode24) begin
        expTp2 <= expTp1;
        expTp1 <= countIn;
      end
      if (hit) expAct <= wrData[6:5];
    end
    started <= 1'b1;
  end

  task automatic cmp(string tag, string sig, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s actual=%0h expected=%0h at %0t", tag, scen, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("R2", "cntRstPulse", 32'(cntRstPulse), 32'(expRst));
      cmp("R3", "zeroEnPulse", 32'(zeroEnPulse), 32'(expZero));
      cmp("R4", "capturePulse", 32'(capturePulse), 32'(expCap));
      cmp("R4", "tp1", 32'(tp1), 32'(expTp1));
      cmp("R4", "tp2", 32'(tp2), 32'(expTp2));
      cmp("R6", "actOut", 32'(actOut), 32'(expAct));
    end
    countIn <= countIn + 24'h01_0203;
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wrEn = 1'b0; wrAddr = '0; wrData = '0;
    end
  endtask

  initial begin
    fork
      begin
        scen = "R1";
        repeat (3) @(negedge clk);
        // R1 reset state checked directly
        cmp("R1", "reset outputs", {actOut, cntRstPulse, zeroEnPulse, capturePulse}, 0);
        cmp("R1", "reset tp", tp1 | tp2, 0);
        @(negedge clk); rstN = 1'b1;
        idle(2);
        scen = "R2";
        wr(8'h30, 8'h01); wr(8'h30, 8'h02); wr(8'h30, 8'h04); idle(2);
        wr(8'h30, 8'h07); wr(8'h30, 8'h05); idle(2);
        scen = "R3";
        wr(8'h30, 8'h08); wr(8'h30, 8'h08); idle(2);
        scen = "R4";
        wr(8'h30, 8'h10); idle(1); wr(8'h30, 8'h10); wr(8'h30, 8'h10); idle(3);
        scen = "R5";
        mode24 = 1'b0;
        wr(8'h30, 8'h10); wr(8'h30, 8'h1F); idle(2);
        mode24 = 1'b1;
        scen = "R6";
        wr(8'h30, 8'h20); idle(2); wr(8'h30, 8'h40); idle(1);
        wr(8'h30, 8'h60); idle(2); wr(8'h30, 8'h01); idle(2);
        wr(8'h30, 8'h7F); idle(2);
        scen = "R7";
        wr(8'h31, 8'hFF); wr(8'h10, 8'h7F); wr(8'hB0, 8'hFF); idle(2);
        scen = "R8";
        wr(8'h30, 8'h80); idle(2); wr(8'h30, 8'hE0); idle(2);
        wr(8'h30, 8'h00); idle(3);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule